// File: doc/BRIEF.md
# Keyboard Controller Host Interface

This block is the byte-wide mailbox between a host and an embedded controller, arranged the way legacy keyboard controllers are. The host sees two ports. A write to either port loads an input byte. A read of the data port returns the controller's output byte, and a read of the command port returns a status byte. The controller reaches the same state through a small byte-addressed register bus. It also gets two interrupt lines: one signals that input has arrived, and one signals that the output byte has been taken.

A control bit picks how the two buffer flags are cleared. In automatic mode, reading or consuming the byte drops the flag. In explicit mode, the controller must write a one to a self-clearing control bit to drop the flag. The host keyboard interrupt line, IRQ1, follows the output-full flag when another control bit is set. When that bit is clear, software drives IRQ1 directly. Register reads and interrupt outputs are combinational. Every state change takes effect on the next rising clock edge.

Top module: `kbc_host_if`

## Requirements
- R1: A controller reset (`rst_n` low at a clock edge) clears the input and output data bytes, the status byte, the control register and the IRQ register. All three interrupt outputs are then 0.
- R2: The controller register addresses are as follows. Address 0 is the input data register (read). Address 1 is the output data register (write only; it reads 0). Address 2 is the status register, where a write changes only bits 7..4. Address 3 is control. Address 4 is the IRQ register, which has bit 0 only. Any other address reads 0.
- R3: A host write stores the byte and sets IBF (status bit 1). It also sets status bit 3 to 1 when the command port was used (`host_cmd_sel`=1) and to 0 when the data port was used.
- R4: A host read of the data port returns the output data byte and clears OBF (status bit 0) in both modes. A host read of the command port returns the status byte and changes nothing.
- R5: A controller write to address 1 sets OBF. When a host data read happens in the same cycle, the set wins.
- R6: With control bit 5 = 0, a controller read of address 0 clears IBF. A control write whose bit 5 is 0 clears no flag, even if its bits 7 or 6 are 1.
- R7: With control bit 5 = 1, reading address 0 leaves IBF set. A control write with bits 5 and 7 set clears IBF, and a control write with bits 5 and 6 set clears OBF. Control bits 7 and 6 always read back 0.
- R8: A host reset (`host_rst_n` low at an edge) clears IBF only. When a host write coincides with a controller clear of IBF, IBF stays set.
- R9: `irq_ibf` is high exactly when control bit 3 and IBF are both 1. `irq_obe` is high exactly when control bit 2 is 1 and OBF is 0.
- R10: When control bit 0 is 1, `irq1` equals OBF. When control bit 0 is 0, `irq1` equals bit 0 of the IRQ register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Controller reset, synchronous, active low |
| host_rst_n | input | 1 | Host reset, synchronous, active low; clears IBF |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_cmd_sel | input | 1 | 1 selects the command/status port, 0 the data port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (output data or status) |
| reg_wr | input | 1 | Controller register write strobe |
| reg_rd | input | 1 | Controller register read strobe |
| reg_addr | input | 3 | Controller register address |
| reg_wdata | input | 8 | Controller write byte |
| reg_rdata | output | 8 | Controller read byte |
| irq_ibf | output | 1 | Controller interrupt: input buffer full |
| irq_obe | output | 1 | Controller interrupt: output buffer empty |
| irq1 | output | 1 | Host keyboard interrupt line |

## Verification
The bench targets the points where the clear mode changes behaviour. A design that tied the clear-on-read to the wrong mode would lose IBF in explicit mode, or keep it forever in automatic mode. It also checks that a write-one clear has no effect unless that same write selects explicit mode, and that the self-clearing bits read back as zero. Two collisions are staged: a host write in the cycle of a controller read, and a controller output write in the cycle of a host data read. If the priority is wrong, the flag ends up clear while a fresh byte is still waiting. The bench also checks that a host reset leaves OBF untouched, that a command-port read has no side effect, and that IRQ1 switches source when control bit 0 changes.

// File: rtl/kbc_pkg.sv
// Shared constants for the keyboard controller host interface.
// Assumes an 8-bit data path; bit positions are fixed by the register layout.
package kbc_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int SW_W   = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_IN   = 3'd0,
        A_OUT  = 3'd1,
        A_STAT = 3'd2,
        A_CTRL = 3'd3,
        A_IRQ  = 3'd4
    } kbc_addr_e;

    // control bit positions
    localparam int C_IRQ1_AUTO = 0;
    localparam int C_OBE_IE    = 2;
    localparam int C_IBF_IE    = 3;
    localparam int C_MODE      = 5;
    localparam int C_CLR_OBF   = 6;
    localparam int C_CLR_IBF   = 7;

    // status bit positions
    localparam int S_OBF = 0;
    localparam int S_IBF = 1;
    localparam int S_CMD = 3;
    localparam int S_SW  = 4;
endpackage

// File: rtl/kbc_buf_flags.sv
// Data bytes and buffer flags. Holds the input byte, the output byte, IBF,
// OBF and the command flag. Assumes single-cycle strobes. A set of a flag
// has priority over a clear in the same cycle; the resets override both.
module kbc_buf_flags
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_cmd_sel,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              out_wr,
    input  logic [DATA_W-1:0] out_wdata,
    input  logic              ibf_clr,
    input  logic              obf_clr,
    output logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] out_data,
    output logic              ibf,
    output logic              obf,
    output logic              cmd_flag
);
    // Input byte and command flag, loaded on every host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_data  <= '0;
            cmd_flag <= 1'b0;
        end else if (host_wr) begin
            in_data  <= host_wdata;
            cmd_flag <= host_cmd_sel;
        end
    end

    // IBF: host write sets it, a controller clear drops it, either reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || !host_rst_n) ibf <= 1'b0;
        else if (host_wr)          ibf <= 1'b1;
        else if (ibf_clr)          ibf <= 1'b0;
    end

    // Output byte, loaded on a controller write.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_data <= '0;
        else if (out_wr) out_data <= out_wdata;
    end

    // OBF: controller write sets it, a host data read or a write-1 clear drops it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                obf <= 1'b0;
        else if (out_wr)                           obf <= 1'b1;
        else if ((host_rd && !host_cmd_sel) || obf_clr) obf <= 1'b0;
    end
endmodule

// File: rtl/kbc_ctrl_regs.sv
// Controller-writable registers: control, IRQ register and the software
// status bits. It also decodes the self-clearing write-one pulses. A pulse
// counts only when the same write selects explicit clear mode.
module kbc_ctrl_regs
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] ctrl,
    output logic              irq_bit,
    output logic [SW_W-1:0]   sw_status,
    output logic              ibf_w1c,
    output logic              obf_w1c
);
    localparam int STORED_W = C_CLR_OBF;  // bits below the pulse bits are stored

    logic [STORED_W-1:0] ctrl_q;
    logic                ctrl_we;

    assign ctrl_we = reg_wr && (reg_addr == A_CTRL);

    // Control register storage; the pulse bits are not stored.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= reg_wdata[STORED_W-1:0];
    end

    // IRQ register, bit 0 only.
    always_ff @(posedge clk) begin
        if (!rst_n)                            irq_bit <= 1'b0;
        else if (reg_wr && reg_addr == A_IRQ)  irq_bit <= reg_wdata[0];
    end

    // Software-owned upper status bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                            sw_status <= '0;
        else if (reg_wr && reg_addr == A_STAT) sw_status <= reg_wdata[DATA_W-1:S_SW];
    end

    // Self-clearing pulses and read-back view with the pulse bits as zero.
    always_comb begin
        ibf_w1c = ctrl_we && reg_wdata[C_MODE] && reg_wdata[C_CLR_IBF];
        obf_w1c = ctrl_we && reg_wdata[C_MODE] && reg_wdata[C_CLR_OBF];
        ctrl    = {{(DATA_W-STORED_W){1'b0}}, ctrl_q};
    end
endmodule

// File: rtl/kbc_irq_gen.sv
// Interrupt outputs. Controller interrupts are gated flags. IRQ1 comes from
// OBF or from the software IRQ bit, as the auto bit selects. Combinational.
module kbc_irq_gen (
    input  logic irq1_auto,
    input  logic obe_ie,
    input  logic ibf_ie,
    input  logic ibf,
    input  logic obf,
    input  logic irq_bit,
    output logic irq_ibf,
    output logic irq_obe,
    output logic irq1
);
    // Gate the flags with their enables and pick the IRQ1 source.
    always_comb begin
        irq_ibf = ibf_ie && ibf;
        irq_obe = obe_ie && !obf;
        irq1    = irq1_auto ? obf : irq_bit;
    end
endmodule

// File: rtl/kbc_host_if.sv
// Top of the keyboard controller host interface. Wires the buffer flags,
// the control registers and the interrupt logic, and muxes both read paths.
// Assumes one-cycle host and controller strobes; reads are combinational.
module kbc_host_if
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_cmd_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_ibf,
    output logic              irq_obe,
    output logic              irq1
);
    logic [DATA_W-1:0] in_data, out_data, ctrl, status;
    logic [SW_W-1:0]   sw_status;
    logic              ibf, obf, cmd_flag, irq_bit;
    logic              ibf_w1c, obf_w1c, ibf_clr, out_wr;

    assign out_wr  = reg_wr && (reg_addr == A_OUT);
    assign ibf_clr = ibf_w1c || (reg_rd && reg_addr == A_IN && !ctrl[C_MODE]);

    kbc_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ctrl(ctrl), .irq_bit(irq_bit),
        .sw_status(sw_status), .ibf_w1c(ibf_w1c), .obf_w1c(obf_w1c)
    );

    kbc_buf_flags u_flags (
        .clk(clk), .rst_n(rst_n), .host_rst_n(host_rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_cmd_sel(host_cmd_sel),
        .host_wdata(host_wdata), .out_wr(out_wr), .out_wdata(reg_wdata),
        .ibf_clr(ibf_clr), .obf_clr(obf_w1c), .in_data(in_data),
        .out_data(out_data), .ibf(ibf), .obf(obf), .cmd_flag(cmd_flag)
    );

    kbc_irq_gen u_irq (
        .irq1_auto(ctrl[C_IRQ1_AUTO]), .obe_ie(ctrl[C_OBE_IE]),
        .ibf_ie(ctrl[C_IBF_IE]), .ibf(ibf), .obf(obf), .irq_bit(irq_bit),
        .irq_ibf(irq_ibf), .irq_obe(irq_obe), .irq1(irq1)
    );

    // Assemble the status byte from flags and software bits.
    always_comb begin
        status        = '0;
        status[S_OBF] = obf;
        status[S_IBF] = ibf;
        status[S_CMD] = cmd_flag;
        status[DATA_W-1:S_SW] = sw_status;
    end

    // Host read path: status on the command port, output byte on the data port.
    assign host_rdata = host_cmd_sel ? status : out_data;

    // Controller read path by address.
    always_comb begin
        case (reg_addr)
            A_IN:    reg_rdata = in_data;
            A_STAT:  reg_rdata = status;
            A_CTRL:  reg_rdata = ctrl;
            A_IRQ:   reg_rdata = {{(DATA_W-1){1'b0}}, irq_bit};
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/kbc_host_if_chk.sv
// Assertion checker for kbc_host_if, attached by bind below.
module kbc_host_if_chk
    import kbc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              host_rst_n,
    input logic              host_wr,
    input logic              host_cmd_sel,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [DATA_W-1:0] ctrl,
    input logic              ibf,
    input logic              obf,
    input logic              cmd_flag,
    input logic              irq_obe
);
    AST_HOST_WR_SETS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_rst_n) |=> ibf);                                  // R3
    AST_CMD_FLAG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (cmd_flag == $past(host_cmd_sel)));                     // R3
    AST_OUT_WR_SETS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_OUT) |=> obf);                             // R5
    AST_IBF_HELD_EXPLICIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ibf && ctrl[C_MODE] && host_rst_n &&
         !(reg_wr && reg_addr == A_CTRL && reg_wdata[C_MODE] && reg_wdata[C_CLR_IBF]))
        |=> ibf);                                                          // R7
    AST_PULSE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_CTRL) |-> (reg_rdata[C_CLR_IBF:C_CLR_OBF] == 2'b00)); // R7
    AST_OBE_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_obe |-> !obf);                                                  // R9
endmodule

bind kbc_host_if kbc_host_if_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_rst_n(host_rst_n), .host_wr(host_wr),
    .host_cmd_sel(host_cmd_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ctrl(ctrl), .ibf(ibf), .obf(obf), .cmd_flag(cmd_flag), .irq_obe(irq_obe)
);

// File: tb/tb_kbc_host_if.sv
`timescale 1ns/1ps
module tb_kbc_host_if;
    logic       clk = 1'b0;
    logic       rst_n, host_rst_n, host_wr, host_rd, host_cmd_sel;
    logic [7:0] host_wdata, host_rdata, reg_wdata, reg_rdata;
    logic       reg_wr, reg_rd, irq_ibf, irq_obe, irq1;
    logic [2:0] reg_addr;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    kbc_host_if dut (
        .clk(clk), .rst_n(rst_n), .host_rst_n(host_rst_n), .host_wr(host_wr),
        .host_rd(host_rd), .host_cmd_sel(host_cmd_sel), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ibf(irq_ibf), .irq_obe(irq_obe), .irq1(irq1)
    );

    // op codes
    localparam logic [1:0] HW = 2'd0, HR = 2'd1, CW = 2'd2, CR = 2'd3;
    localparam logic [2:0] DP = 3'd0, CP = 3'd1;  // host port: data / command
    // vector: op[24:23] addr[22:20] wdata[19:12] expected[11:4] req[3:0] (0 = no check)
    localparam int NV = 32;
    localparam logic [24:0] VEC [NV] = '{
        {CR, 3'd2, 8'h00, 8'h00, 4'd1},  // R1 status after reset
        {CR, 3'd3, 8'h00, 8'h00, 4'd1},  // R1 control after reset
        {HW, CP,   8'hAA, 8'h00, 4'd0},
        {HR, CP,   8'h00, 8'h0A, 4'd3},  // R3 IBF + command flag
        {HR, CP,   8'h00, 8'h0A, 4'd4},  // R4 status read has no side effect
        {CR, 3'd0, 8'h00, 8'hAA, 4'd6},  // R6 read input byte
        {HR, CP,   8'h00, 8'h08, 4'd6},  // R6 IBF cleared by read
        {HW, DP,   8'h55, 8'h00, 4'd0},
        {HR, CP,   8'h00, 8'h02, 4'd3},  // R3 data port clears command flag
        {CW, 3'd1, 8'h3C, 8'h00, 4'd0},
        {CR, 3'd2, 8'h00, 8'h03, 4'd5},  // R5 OBF set
        {HR, DP,   8'h00, 8'h3C, 4'd4},  // R4 data read
        {HR, CP,   8'h00, 8'h02, 4'd4},  // R4 OBF cleared
        {CR, 3'd0, 8'h00, 8'h55, 4'd6},
        {CW, 3'd2, 8'hF5, 8'h00, 4'd0},
        {CR, 3'd2, 8'h00, 8'hF0, 4'd2},  // R2 only bits 7..4 writable
        {CW, 3'd3, 8'h20, 8'h00, 4'd0},
        {HW, CP,   8'h11, 8'h00, 4'd0},
        {CR, 3'd0, 8'h00, 8'h11, 4'd7},
        {CR, 3'd2, 8'h00, 8'hFA, 4'd7},  // R7 read keeps IBF in explicit mode
        {CW, 3'd3, 8'hA0, 8'h00, 4'd0},
        {CR, 3'd2, 8'h00, 8'hF8, 4'd7},  // R7 write-1 cleared IBF
        {CR, 3'd3, 8'h00, 8'h20, 4'd7},  // R7 pulse bits read 0
        {CW, 3'd1, 8'h77, 8'h00, 4'd0},
        {CW, 3'd3, 8'h60, 8'h00, 4'd0},
        {CR, 3'd2, 8'h00, 8'hF8, 4'd7},  // R7 write-1 cleared OBF
        {CW, 3'd1, 8'h78, 8'h00, 4'd0},
        {HR, DP,   8'h00, 8'h78, 4'd4},
        {CR, 3'd2, 8'h00, 8'hF8, 4'd4},
        {CR, 3'd1, 8'h00, 8'h00, 4'd2},  // R2 output register reads 0
        {CW, 3'd2, 8'h00, 8'h00, 4'd0},
        {CW, 3'd3, 8'h00, 8'h00, 4'd0}
    };

    task automatic check(input string what, input int req, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        host_wr = 0; host_rd = 0; host_cmd_sel = 0; host_wdata = 0;
        reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    endtask

    // one operation per cycle; read data is checked before the edge
    task automatic do_op(input logic [1:0] op, input logic [2:0] a,
                         input logic [7:0] wd, input logic [7:0] exp, input int req);
        @(negedge clk);
        idle();
        case (op)
            HW: begin host_wr = 1; host_cmd_sel = a[0]; host_wdata = wd; end
            HR: begin host_rd = 1; host_cmd_sel = a[0]; end
            CW: begin reg_wr = 1; reg_addr = a; reg_wdata = wd; end
            default: begin reg_rd = 1; reg_addr = a; end
        endcase
        #1;
        if (req != 0)
            check($sformatf("vector op=%0d addr=%0d", op, a), req,
                  (op == HR) ? host_rdata : reg_rdata, exp);
        @(posedge clk);
        #1 idle();
    endtask

    task automatic chk_irq(input int req, input logic ei, input logic eo, input logic e1);
        @(negedge clk);
        check("irq_ibf", req, {7'd0, irq_ibf}, {7'd0, ei});
        check("irq_obe", req, {7'd0, irq_obe}, {7'd0, eo});
        check("irq1",    req, {7'd0, irq1},    {7'd0, e1});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0; host_rst_n = 1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        chk_irq(1, 0, 0, 0);  // R1 interrupt outputs after reset

        for (int i = 0; i < NV; i++)
            do_op(VEC[i][24:23], VEC[i][22:20], VEC[i][19:12], VEC[i][11:4], int'(VEC[i][3:0]));

        // R9 R10: enables and IRQ1 source
        do_op(CW, 3'd3, 8'h0D, 8'h00, 0);
        chk_irq(9, 0, 1, 0);
        do_op(CW, 3'd1, 8'h99, 8'h00, 0);
        chk_irq(10, 0, 0, 1);
        do_op(HW, DP, 8'h01, 8'h00, 0);
        chk_irq(9, 1, 0, 1);
        do_op(CW, 3'd3, 8'h00, 8'h00, 0);
        chk_irq(10, 0, 0, 0);  // OBF set but IRQ1 now from IRQ register
        do_op(CW, 3'd4, 8'h01, 8'h00, 0);
        chk_irq(10, 0, 0, 1);
        do_op(CR, 3'd4, 8'h00, 8'h01, 2);
        do_op(CW, 3'd4, 8'h00, 8'h00, 0);
        chk_irq(10, 0, 0, 0);

        // R6: pulse bits ignored when the write selects automatic mode
        do_op(CW, 3'd3, 8'hC0, 8'h00, 0);
        do_op(CR, 3'd2, 8'h00, 8'h03, 6);
        do_op(CR, 3'd3, 8'h00, 8'h00, 6);

        // R8: host reset clears IBF only
        @(negedge clk); host_rst_n = 0;
        @(posedge clk); #1 host_rst_n = 1;
        do_op(CR, 3'd2, 8'h00, 8'h01, 8);

        // R8: host write collides with a clearing controller read
        do_op(HW, DP, 8'h22, 8'h00, 0);
        @(negedge clk);
        host_wr = 1; host_wdata = 8'h33; reg_rd = 1; reg_addr = 3'd0;
        @(posedge clk); #1 idle();
        do_op(CR, 3'd2, 8'h00, 8'h03, 8);
        do_op(CR, 3'd0, 8'h00, 8'h33, 8);

        // R5: controller output write collides with a host data read
        @(negedge clk);
        host_rd = 1; reg_wr = 1; reg_addr = 3'd1; reg_wdata = 8'h44;
        @(posedge clk); #1 idle();
        do_op(CR, 3'd2, 8'h00, 8'h01, 5);
        do_op(HR, DP, 8'h00, 8'h44, 5);

        // R1: controller reset after state is loaded
        do_op(CW, 3'd3, 8'h0D, 8'h00, 0);
        do_op(CW, 3'd2, 8'hF0, 8'h00, 0);
        do_op(CW, 3'd4, 8'h01, 8'h00, 0);
        do_op(HW, CP, 8'h5A, 8'h00, 0);
        @(negedge clk); rst_n = 0;
        @(posedge clk); #1 rst_n = 1;
        do_op(CR, 3'd2, 8'h00, 8'h00, 1);
        do_op(CR, 3'd3, 8'h00, 8'h00, 1);
        do_op(CR, 3'd4, 8'h00, 8'h00, 1);
        do_op(CR, 3'd0, 8'h00, 8'h00, 1);
        chk_irq(1, 0, 0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule